// File: doc/BRIEF.md
# Serial Audio Control Register Port

This block is the configuration port of a stereo audio converter. A 16-bit control word arrives one bit at a time on a single data pin. A rising edge on the serial clock pin shifts in one bit, most significant bit first. A rising edge on a separate strobe pin then writes the word into the register that its address field selects. All pins are sampled on the system clock and are assumed to be synchronous to it already. Edges are found by comparing each pin with its value on the previous cycle.

Left and right attenuation each have a staging register and an active register. A write with its commit bit at 0 updates the staging register only. A write with its commit bit at 1 moves both staged values into the active pair at the same time, so the two channels change level together. Two mode registers hold the format and filter controls. A fifth register is hidden: it accepts writes only while the first mode register holds an unlock pattern. While the hardware-mode pin is high, every software write is dropped.

Top module: `audcfg_top`

## Requirements
- R1: After reset both active attenuation codes and both staged codes are 0xFF, and every other register bit and output is 0.
- R2: A word is shifted MSB first. Address = word[11:9], data = word[8:0], and word[15:12] has no effect. A write happens on a strobe rising edge only when exactly 16 serial clock rising edges were seen since the previous strobe.
- R3: A write to address 0 (left) or address 1 (right) with data[8]=0 stores data[7:0] in that channel's staging register and leaves both active codes unchanged.
- R4: A write to address 0 or 1 with data[8]=1 stores data[7:0] as that channel's staged code. In the same write, both active codes take the staged values of their channels.
- R5: mute_l_o is 1 exactly when the active left code is 0, and mute_r_o is 1 exactly when the active right code is 0.
- R6: Address 2 holds data[8:0]. Its fields are bit0 soft_mute_o, bit1 deemph_o, bit2 pwr_dn_o, bits[4:3] word_len_o, and bits[8:5] the unlock field. Address 3 holds bit0-1 fmt_o, bit2 lr_pol_o, bit3 atten_link_o, bit4 slow_roll_o, bit5 phase_rev_o and bit6 rate_sel_o.
- R7: Address 6 writes data[3:0] to the hidden register (bit0 zero_det_o, bits[2:1] diff_mode_o, bit3 clk_det_dis_o). The write is accepted only while the address 2 unlock field holds 4'b1111. Otherwise it changes nothing.
- R8: While hw_mode_i is 1, a strobe changes no register.
- R9: A strobe that follows any number of serial clock edges other than 16 changes no register. Every strobe clears the bit counter.
- R10: A write to address 4, 5 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock; rising edge shifts in a bit |
| sdi_i | input | 1 | Serial data, MSB first |
| lat_i | input | 1 | Write strobe; rising edge commits the word |
| hw_mode_i | input | 1 | Hardware mode; blocks software writes |
| atten_l_o | output | 8 | Active left attenuation code |
| atten_r_o | output | 8 | Active right attenuation code |
| mute_l_o | output | 1 | Left active code is zero |
| mute_r_o | output | 1 | Right active code is zero |
| soft_mute_o | output | 1 | Soft mute request |
| deemph_o | output | 1 | De-emphasis enable |
| pwr_dn_o | output | 1 | Converter power-down |
| word_len_o | output | 2 | Input sample width select |
| fmt_o | output | 2 | Sample data format select |
| lr_pol_o | output | 1 | Frame clock polarity |
| atten_link_o | output | 1 | Attenuator mode control |
| slow_roll_o | output | 1 | Slow roll-off filter select |
| phase_rev_o | output | 1 | Output phase invert |
| rate_sel_o | output | 1 | Sample rate range select |
| zero_det_o | output | 1 | Zero detect enable (hidden register) |
| diff_mode_o | output | 2 | Differential output mode (hidden register) |
| clk_det_dis_o | output | 1 | Clock loss detect disable (hidden register) |

## Verification
The checker tests five rules on every cycle. The active attenuation pair moves only on a commit write. No output moves in hardware mode or after a strobe with a miscounted word. The hidden register stays fixed while locked, and the counter reads zero after each strobe. The bench has to show the rest with its own model: the MSB-first bit order, the field positions, that a commit takes the staged value of the other channel, and the mute flags at code zero. Its random sequence mixes addresses, commit bits, unlock patterns, hardware-mode windows and wrong bit counts.

// File: rtl/audcfg_pkg.sv
package audcfg_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_LSB = 9;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 9;
  localparam int ATT_W    = 8;
  localparam int CNT_W    = $clog2(WORD_W + 2);
  localparam int M3_W     = 7;
  localparam int HID_W    = 4;
  localparam logic [3:0] UNLOCK_PAT = 4'b1111;

  typedef enum logic [ADDR_W-1:0] {
    A_ATT_L = 3'd0,
    A_ATT_R = 3'd1,
    A_MODE0 = 3'd2,
    A_MODE1 = 3'd3,
    A_HID   = 3'd6
  } addr_e;
endpackage

// File: rtl/audcfg_shift.sv
module audcfg_shift
  import audcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              lat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_stb_o,
  output logic              lat_rise_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic sck_q, lat_q;
  logic sck_rise;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;

  assign sck_rise   = sck_i & ~sck_q;
  assign lat_rise_o = lat_i & ~lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      lat_q   <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sck_q <= sck_i;
      lat_q <= lat_i;
      if (lat_rise_o) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        shift_q <= {shift_q[WORD_W-2:0], sdi_i};
        // saturate: any count past full marks the word invalid
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o   = shift_q;
  assign cnt_o    = cnt_q;
  assign wr_stb_o = lat_rise_o && (cnt_q == CNT_FULL);
endmodule

// File: rtl/audcfg_regs.sv
module audcfg_regs
  import audcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ATT_W-1:0]  act_l_o,
  output logic [ATT_W-1:0]  act_r_o,
  output logic [DATA_W-1:0] mode0_o,
  output logic [M3_W-1:0]   mode1_o,
  output logic [HID_W-1:0]  hid_o,
  output logic              unlocked_o
);
  logic [ATT_W-1:0]  stg_l_q, stg_r_q, act_l_q, act_r_q;
  logic [DATA_W-1:0] mode0_q;
  logic [M3_W-1:0]   mode1_q;
  logic [HID_W-1:0]  hid_q;
  logic              commit;

  assign unlocked_o = (mode0_q[8:5] == UNLOCK_PAT);
  assign commit     = data_i[ATT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_l_q <= '1;
      stg_r_q <= '1;
      act_l_q <= '1;
      act_r_q <= '1;
      mode0_q <= '0;
      mode1_q <= '0;
      hid_q   <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_ATT_L: begin
          stg_l_q <= data_i[ATT_W-1:0];
          if (commit) begin
            act_l_q <= data_i[ATT_W-1:0];
            act_r_q <= stg_r_q;
          end
        end
        A_ATT_R: begin
          stg_r_q <= data_i[ATT_W-1:0];
          if (commit) begin
            act_l_q <= stg_l_q;
            act_r_q <= data_i[ATT_W-1:0];
          end
        end
        A_MODE0: mode0_q <= data_i;
        A_MODE1: mode1_q <= data_i[M3_W-1:0];
        A_HID:   if (unlocked_o) hid_q <= data_i[HID_W-1:0];
        default: ;
      endcase
    end
  end

  assign act_l_o = act_l_q;
  assign act_r_o = act_r_q;
  assign mode0_o = mode0_q;
  assign mode1_o = mode1_q;
  assign hid_o   = hid_q;
endmodule

// File: rtl/audcfg_top.sv
module audcfg_top
  import audcfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       sdi_i,
  input  logic       lat_i,
  input  logic       hw_mode_i,
  output logic [7:0] atten_l_o,
  output logic [7:0] atten_r_o,
  output logic       mute_l_o,
  output logic       mute_r_o,
  output logic       soft_mute_o,
  output logic       deemph_o,
  output logic       pwr_dn_o,
  output logic [1:0] word_len_o,
  output logic [1:0] fmt_o,
  output logic       lr_pol_o,
  output logic       atten_link_o,
  output logic       slow_roll_o,
  output logic       phase_rev_o,
  output logic       rate_sel_o,
  output logic       zero_det_o,
  output logic [1:0] diff_mode_o,
  output logic       clk_det_dis_o
);
  logic [WORD_W-1:0] word;
  logic              wr_stb, lat_rise, unlocked;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ATT_W-1:0]  act [2];
  logic [DATA_W-1:0] mode0;
  logic [M3_W-1:0]   mode1;
  logic [HID_W-1:0]  hid;
  logic [1:0]        mute;

  audcfg_shift u_shift (
    .clk_i, .rst_ni, .sck_i, .sdi_i, .lat_i,
    .word_o(word), .wr_stb_o(wr_stb), .lat_rise_o(lat_rise), .cnt_o(bit_cnt)
  );

  audcfg_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(wr_stb & ~hw_mode_i),
    .addr_i(word[ADDR_LSB +: ADDR_W]),
    .data_i(word[DATA_W-1:0]),
    .act_l_o(act[0]), .act_r_o(act[1]),
    .mode0_o(mode0), .mode1_o(mode1), .hid_o(hid), .unlocked_o(unlocked)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_mute
    assign mute[ch] = (act[ch] == '0);
  end

  assign atten_l_o     = act[0];
  assign atten_r_o     = act[1];
  assign mute_l_o      = mute[0];
  assign mute_r_o      = mute[1];
  assign soft_mute_o   = mode0[0];
  assign deemph_o      = mode0[1];
  assign pwr_dn_o      = mode0[2];
  assign word_len_o    = mode0[4:3];
  assign fmt_o         = mode1[1:0];
  assign lr_pol_o      = mode1[2];
  assign atten_link_o  = mode1[3];
  assign slow_roll_o   = mode1[4];
  assign phase_rev_o   = mode1[5];
  assign rate_sel_o    = mode1[6];
  assign zero_det_o    = hid[0];
  assign diff_mode_o   = hid[2:1];
  assign clk_det_dis_o = hid[3];
endmodule

// File: rtl/audcfg_chk.sv
module audcfg_chk
  import audcfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_mode_i,
  input logic              lat_rise,
  input logic              wr_stb,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              unlocked,
  input logic [WORD_W-1:0] word,
  input logic [7:0]        atten_l_o,
  input logic [7:0]        atten_r_o,
  input logic [33:0]       all_o,
  input logic [3:0]        hid_o
);
  logic att_addr, commit_wr;
  assign att_addr  = (word[ADDR_LSB +: ADDR_W] == A_ATT_L) || (word[ADDR_LSB +: ADDR_W] == A_ATT_R);
  assign commit_wr = wr_stb && !hw_mode_i && att_addr && word[ATT_W];

  p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_wr |=> ($stable(atten_l_o) && $stable(atten_r_o)));

  p_hw_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_mode_i |=> $stable(all_o));

  p_short_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_rise && bit_cnt != CNT_W'(WORD_W)) |=> $stable(all_o));

  p_cnt_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_rise |=> (bit_cnt == '0));

  p_hidden_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(hid_o));
endmodule

bind audcfg_top audcfg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hw_mode_i(hw_mode_i),
  .lat_rise(lat_rise), .wr_stb(wr_stb), .bit_cnt(bit_cnt),
  .unlocked(unlocked), .word(word),
  .atten_l_o(atten_l_o), .atten_r_o(atten_r_o),
  .all_o({atten_l_o, atten_r_o, mute_l_o, mute_r_o, soft_mute_o, deemph_o,
          pwr_dn_o, word_len_o, fmt_o, lr_pol_o, atten_link_o, slow_roll_o,
          phase_rev_o, rate_sel_o, zero_det_o, diff_mode_o, clk_det_dis_o}),
  .hid_o({clk_det_dis_o, diff_mode_o, zero_det_o})
);

// File: tb/sim_audcfg_top.sv
module sim_audcfg_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, lat = 1'b0, hw = 1'b0;
  logic [7:0] att_l, att_r;
  logic mute_l, mute_r, smute, deemph, pdn, lrp, link, slow, rev, rate, zdet, cdd;
  logic [1:0] wlen, fmt, diff;

  int checks = 0, fails = 0;

  logic [7:0] m_stg_l, m_stg_r, m_act_l, m_act_r;
  logic [8:0] m_r2;
  logic [6:0] m_r3;
  logic [3:0] m_r4;

  always #(CLK_PERIOD/2) clk = ~clk;

  audcfg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .lat_i(lat), .hw_mode_i(hw),
    .atten_l_o(att_l), .atten_r_o(att_r), .mute_l_o(mute_l), .mute_r_o(mute_r),
    .soft_mute_o(smute), .deemph_o(deemph), .pwr_dn_o(pdn), .word_len_o(wlen),
    .fmt_o(fmt), .lr_pol_o(lrp), .atten_link_o(link), .slow_roll_o(slow),
    .phase_rev_o(rev), .rate_sel_o(rate), .zero_det_o(zdet), .diff_mode_o(diff),
    .clk_det_dis_o(cdd)
  );

  function automatic logic [33:0] act_vec();
    return {att_l, att_r, mute_l, mute_r, smute, deemph, pdn, wlen, fmt, lrp,
            link, slow, rev, rate, zdet, diff, cdd};
  endfunction

  function automatic logic [33:0] exp_vec();
    return {m_act_l, m_act_r, m_act_l == 8'd0, m_act_r == 8'd0, m_r2[0], m_r2[1],
            m_r2[2], m_r2[4:3], m_r3[1:0], m_r3[2], m_r3[3], m_r3[4], m_r3[5],
            m_r3[6], m_r4[0], m_r4[2:1], m_r4[3]};
  endfunction

  task automatic model_reset();
    m_stg_l = 8'hFF; m_stg_r = 8'hFF; m_act_l = 8'hFF; m_act_r = 8'hFF;
    m_r2 = '0; m_r3 = '0; m_r4 = '0;
  endtask

  task automatic model_apply(input logic [15:0] w, input int nbits, input logic hw_v);
    logic [8:0] d;
    d = w[8:0];
    if (nbits != 16 || hw_v) return;
    case (w[11:9])
      3'd0: begin m_stg_l = d[7:0]; if (d[8]) begin m_act_l = m_stg_l; m_act_r = m_stg_r; end end
      3'd1: begin m_stg_r = d[7:0]; if (d[8]) begin m_act_l = m_stg_l; m_act_r = m_stg_r; end end
      3'd2: m_r2 = d;
      3'd3: m_r3 = d[6:0];
      3'd6: if (m_r2[8:5] == 4'hF) m_r4 = d[3:0];
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input logic hw_v, input string tag);
    hw = hw_v;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = (i < 16) ? w[i] : 1'b1;
      sck = 1'b1;
      @(negedge clk);
      sck = 1'b0;
      @(negedge clk);
    end
    lat = 1'b1;
    @(negedge clk);
    lat = 1'b0;
    @(negedge clk);
    hw = 1'b0;
    model_apply(w, nbits, hw_v);
    check(tag, act_vec(), exp_vec());
  endtask

  function automatic logic [15:0] mk(input logic [3:0] junk, input logic [2:0] a, input logic [8:0] d);
    return {junk, a, d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", act_vec(), exp_vec());

    // R2: junk in upper nibble, MSB-first order into mode register 1
    send(mk(4'hA, 3'd3, 9'h055), 16, 1'b0, "R2 bit order and ignored high bits");
    send(mk(4'h5, 3'd2, 9'h01A), 16, 1'b0, "R6 mode register 0 fields");
    // R3: stage left and right, active unchanged
    send(mk(4'h0, 3'd0, 9'h040), 16, 1'b0, "R3 left stage only");
    send(mk(4'h0, 3'd1, 9'h000), 16, 1'b0, "R3 right stage only");
    // R4: commit from left write takes staged right (0) -> R5 right mute
    send(mk(4'h0, 3'd0, 9'h140), 16, 1'b0, "R4 joint commit");
    checks++;
    if (mute_r !== 1'b1 || mute_l !== 1'b0) begin
      fails++;
      $display("FAIL R5 mute flags: actual %b%b expected 01", mute_l, mute_r);
    end
    // R7: hidden write while locked
    send(mk(4'h0, 3'd6, 9'h00F), 16, 1'b0, "R7 hidden locked");
    send(mk(4'h0, 3'd2, 9'h1E0), 16, 1'b0, "R7 unlock pattern");
    send(mk(4'h0, 3'd6, 9'h00B), 16, 1'b0, "R7 hidden unlocked");
    // R8: hardware mode drops write
    send(mk(4'h0, 3'd3, 9'h07F), 16, 1'b1, "R8 hw mode ignore");
    // R9: short and long words dropped; counter cleared after
    send(mk(4'h0, 3'd3, 9'h07F), 15, 1'b0, "R9 short word dropped");
    send(mk(4'h0, 3'd3, 9'h07F), 18, 1'b0, "R9 long word dropped");
    send(mk(4'h0, 3'd3, 9'h02A), 16, 1'b0, "R9 counter cleared by strobe");
    // R10: undefined addresses
    send(mk(4'h0, 3'd4, 9'h1FF), 16, 1'b0, "R10 addr 4 ignored");
    send(mk(4'h0, 3'd5, 9'h1FF), 16, 1'b0, "R10 addr 5 ignored");
    send(mk(4'h0, 3'd7, 9'h1FF), 16, 1'b0, "R10 addr 7 ignored");

    for (int n = 0; n < 300; n++) begin
      logic [15:0] w;
      int nb;
      logic h;
      w  = 16'($urandom);
      if (w[11:9] == 3'd2 && ($urandom % 2) == 0) w[8:5] = 4'hF;
      nb = (($urandom % 8) == 0) ? int'(1 + $urandom % 20) : 16;
      h  = (($urandom % 6) == 0);
      send(w, nb, h, "R2 random word");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule